// File: doc/BRIEF.md
# Return-From-Trap Commit Unit

This block works out what a return-from-trap instruction does to the program counter and the processor status bits. The instruction is presented on one cycle with `valid_i`, together with the current PC, the debug-select bit taken from the instruction word, the live supervisor, trap-enable and previous-supervisor bits, the debug-state flag, and the two saved return addresses with the saved break status. One clock edge later the block presents the result on its outputs: the next PC, the new supervisor and trap-enable bits, a pulse that clears the debug-state flag, a halt request and an illegal-instruction request.

The outcome is chosen by a fixed priority. A user-mode attempt only steps past the instruction. The privilege fault for that case is raised by other logic. A supervisor attempt with traps still enabled is an error. Otherwise the block takes the normal return or the debug return, depending on whether the debug state and the debug-select bit agree. If they do not agree, the instruction does nothing except step past itself. The surrounding core owns the status registers and writes the presented values back when `commit_o` is high.

Top module: `rett_unit`

## Requirements
- R1: While `rst_ni` is low and after reset until the first accepted instruction, `commit_o`, `next_pc_o`, `s_o`, `et_o`, `dbg_clr_o`, `halt_o` and `illegal_o` are all 0.
- R2: With `s_i`=0, the result has `next_pc_o` = `pc_i`+4, `s_o`/`et_o` equal to the inputs, `illegal_o`=0 and `dbg_clr_o`=0. `halt_o` is 1 exactly when `et_i`=0.
- R3: With `s_i`=1 and `et_i`=1, the result has `halt_o`=1, `illegal_o`=1, `next_pc_o` = `pc_i`+4, status bits unchanged and `dbg_clr_o`=0.
- R4: With `s_i`=1, `et_i`=0, `dbg_state_i`=0 and `dbg_field_i`=0, the result has `next_pc_o` = `pcsr_i`, `et_o`=1, `s_o` = `ps_i`, and no halt, illegal or debug clear.
- R5: With `s_i`=1, `et_i`=0, `dbg_state_i`=1 and `dbg_field_i`=1, the result has `next_pc_o` = `bpcsr_i`, `s_o` = `bs_i`, `et_o` = `bet_i`, `dbg_clr_o`=1, and no halt or illegal request.
- R6: With `s_i`=1 and `et_i`=0, if `dbg_state_i` differs from `dbg_field_i`, the result has `next_pc_o` = `pc_i`+4, status bits unchanged, and no halt, illegal or debug clear.
- R7: A result appears on the clock edge that samples `valid_i`=1. `commit_o` is high for exactly that following cycle. `halt_o`, `illegal_o` and `dbg_clr_o` are 0 whenever `commit_o` is 0.
- R8: The saved return addresses pass through bit for bit, including the low two bits.
- R9: The step of 4 wraps modulo 2^32, so `pc_i`=0xFFFFFFFC gives `next_pc_o`=0.
- R10: The user-mode check takes precedence over the debug match. With `s_i`=0, `dbg_state_i`=1 and `dbg_field_i`=1, the result is the R2 result and `dbg_clr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Return instruction presented this cycle |
| pc_i | input | 32 | PC of the return instruction |
| dbg_field_i | input | 1 | Debug-select bit from the instruction |
| s_i | input | 1 | Current supervisor bit |
| et_i | input | 1 | Current trap-enable bit |
| ps_i | input | 1 | Previous-supervisor bit |
| dbg_state_i | input | 1 | Core is in debug state |
| pcsr_i | input | 32 | Normal saved return PC |
| bpcsr_i | input | 32 | Break saved return PC |
| bs_i | input | 1 | Saved supervisor bit for break return |
| bet_i | input | 1 | Saved trap-enable bit for break return |
| commit_o | output | 1 | Result valid this cycle |
| next_pc_o | output | 32 | PC after the instruction |
| s_o | output | 1 | New supervisor bit |
| et_o | output | 1 | New trap-enable bit |
| dbg_clr_o | output | 1 | Clear the debug-state flag |
| halt_o | output | 1 | Halt request |
| illegal_o | output | 1 | Illegal-instruction request |

## Verification
Each of the five outcome classes is driven with saved addresses, previous-supervisor values and break-status values that differ from the live ones. This shows which source each output was taken from. The two mismatch combinations of debug state and debug-select bit are tried separately, and so is user mode with both debug inputs high. These cases separate the fall-through from a wrongly taken return and check the priority order. A saved address with its low bits set and a PC at the top of the address space expose any masking or carry handling. A cycle without `valid_i` after each result checks that the pulses last one cycle.

// File: rtl/rett_pkg.sv
package rett_pkg;
  typedef enum logic [2:0] {
    RP_USER   = 3'd0,
    RP_ET_ERR = 3'd1,
    RP_NORMAL = 3'd2,
    RP_DEBUG  = 3'd3,
    RP_NOP    = 3'd4
  } rett_path_e;

  typedef struct packed {
    logic s;
    logic et;
    logic dbg_clr;
    logic halt;
    logic illegal;
  } rett_flags_t;
endpackage

// File: rtl/rett_classify.sv
module rett_classify
  import rett_pkg::*;
(
  input  logic       s_i,
  input  logic       et_i,
  input  logic       dbg_state_i,
  input  logic       dbg_field_i,
  output rett_path_e path_o
);
  // priority: user mode, enabled traps, debug match
  always_comb begin
    if (!s_i)                              path_o = RP_USER;
    else if (et_i)                         path_o = RP_ET_ERR;
    else if (!dbg_state_i && !dbg_field_i) path_o = RP_NORMAL;
    else if (dbg_state_i && dbg_field_i)   path_o = RP_DEBUG;
    else                                   path_o = RP_NOP;
  end
endmodule

// File: rtl/rett_compute.sv
module rett_compute
  import rett_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  rett_path_e       path_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  pcsr_i,
  input  logic [PC_W-1:0]  bpcsr_i,
  input  logic             s_i,
  input  logic             et_i,
  input  logic             ps_i,
  input  logic             bs_i,
  input  logic             bet_i,
  output logic [PC_W-1:0]  pc_nxt_o,
  output rett_flags_t      flags_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  logic [PC_W-1:0] pc_seq;
  assign pc_seq = pc_i + STEP;

  always_comb begin
    pc_nxt_o        = pc_seq;
    flags_o.s       = s_i;
    flags_o.et      = et_i;
    flags_o.dbg_clr = 1'b0;
    flags_o.halt    = 1'b0;
    flags_o.illegal = 1'b0;
    unique case (path_i)
      RP_USER:   flags_o.halt = !et_i;
      RP_ET_ERR: begin
        flags_o.halt    = 1'b1;
        flags_o.illegal = 1'b1;
      end
      RP_NORMAL: begin
        pc_nxt_o   = pcsr_i;
        flags_o.et = 1'b1;
        flags_o.s  = ps_i;
      end
      RP_DEBUG: begin
        pc_nxt_o        = bpcsr_i;
        flags_o.et      = bet_i;
        flags_o.s       = bs_i;
        flags_o.dbg_clr = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rett_commit_reg.sv
module rett_commit_reg
  import rett_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_nxt_i,
  input  rett_flags_t     flags_i,
  output logic            commit_o,
  output logic [PC_W-1:0] pc_o,
  output rett_flags_t     flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o <= 1'b0;
      pc_o     <= '0;
      flags_o  <= '0;
    end else begin
      commit_o <= valid_i;
      if (valid_i) begin
        pc_o    <= pc_nxt_i;
        flags_o <= flags_i;
      end else begin
        // status holds, requests are single-cycle
        flags_o.dbg_clr <= 1'b0;
        flags_o.halt    <= 1'b0;
        flags_o.illegal <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rett_unit.sv
module rett_unit
  import rett_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            dbg_field_i,
  input  logic            s_i,
  input  logic            et_i,
  input  logic            ps_i,
  input  logic            dbg_state_i,
  input  logic [PC_W-1:0] pcsr_i,
  input  logic [PC_W-1:0] bpcsr_i,
  input  logic            bs_i,
  input  logic            bet_i,
  output logic            commit_o,
  output logic [PC_W-1:0] next_pc_o,
  output logic            s_o,
  output logic            et_o,
  output logic            dbg_clr_o,
  output logic            halt_o,
  output logic            illegal_o
);
  rett_path_e      path;
  logic [PC_W-1:0] pc_nxt;
  rett_flags_t     flags_nxt, flags_q;

  rett_classify u_classify (
    .s_i         (s_i),
    .et_i        (et_i),
    .dbg_state_i (dbg_state_i),
    .dbg_field_i (dbg_field_i),
    .path_o      (path)
  );

  rett_compute #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_compute (
    .path_i   (path),
    .pc_i     (pc_i),
    .pcsr_i   (pcsr_i),
    .bpcsr_i  (bpcsr_i),
    .s_i      (s_i),
    .et_i     (et_i),
    .ps_i     (ps_i),
    .bs_i     (bs_i),
    .bet_i    (bet_i),
    .pc_nxt_o (pc_nxt),
    .flags_o  (flags_nxt)
  );

  rett_commit_reg #(.PC_W(PC_W)) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .pc_nxt_i (pc_nxt),
    .flags_i  (flags_nxt),
    .commit_o (commit_o),
    .pc_o     (next_pc_o),
    .flags_o  (flags_q)
  );

  assign s_o       = flags_q.s;
  assign et_o      = flags_q.et;
  assign dbg_clr_o = flags_q.dbg_clr;
  assign halt_o    = flags_q.halt;
  assign illegal_o = flags_q.illegal;
endmodule

// File: rtl/rett_unit_chk.sv
module rett_unit_chk #(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [PC_W-1:0] pc_i,
  input logic            dbg_field_i,
  input logic            s_i,
  input logic            et_i,
  input logic            ps_i,
  input logic            dbg_state_i,
  input logic [PC_W-1:0] pcsr_i,
  input logic [PC_W-1:0] bpcsr_i,
  input logic            bs_i,
  input logic            bet_i,
  input logic            commit_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic            s_o,
  input logic            et_o,
  input logic            dbg_clr_o,
  input logic            halt_o,
  input logic            illegal_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  AST_COMMIT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> commit_o); // R7
  AST_COMMIT_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !commit_o); // R7
  AST_PULSE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |-> !(halt_o || illegal_o || dbg_clr_o)); // R7
  AST_USER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !s_i |=> !illegal_o && !dbg_clr_o
      && next_pc_o == $past(pc_i) + STEP && halt_o == !$past(et_i)); // R2
  AST_ET_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && s_i && et_i |=> halt_o && illegal_o
      && next_pc_o == $past(pc_i) + STEP); // R3
  AST_NORMAL_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && s_i && !et_i && !dbg_state_i && !dbg_field_i |=> et_o
      && s_o == $past(ps_i) && next_pc_o == $past(pcsr_i) && !halt_o); // R4
  AST_DEBUG_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && s_i && !et_i && dbg_state_i && dbg_field_i |=> dbg_clr_o
      && s_o == $past(bs_i) && et_o == $past(bet_i)
      && next_pc_o == $past(bpcsr_i)); // R5
  AST_MISMATCH_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && s_i && !et_i && (dbg_state_i != dbg_field_i) |=> !halt_o
      && !illegal_o && !dbg_clr_o && s_o && !et_o
      && next_pc_o == $past(pc_i) + STEP); // R6
endmodule

bind rett_unit rett_unit_chk #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_chk (.*);

// File: tb/rett_unit_tb_top.sv
`timescale 1ns/1ps
module rett_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] pc = '0, pcsr = '0, bpcsr = '0;
  logic        fld = 1'b0, s = 1'b0, et = 1'b0, ps = 1'b0, dst = 1'b0, bs = 1'b0, bet = 1'b0;
  logic        commit, s_q, et_q, dclr, halt, ill;
  logic [31:0] npc;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rett_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pc_i(pc),
    .dbg_field_i(fld), .s_i(s), .et_i(et), .ps_i(ps), .dbg_state_i(dst),
    .pcsr_i(pcsr), .bpcsr_i(bpcsr), .bs_i(bs), .bet_i(bet),
    .commit_o(commit), .next_pc_o(npc), .s_o(s_q), .et_o(et_q),
    .dbg_clr_o(dclr), .halt_o(halt), .illegal_o(ill)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, result visible at the following negedge
  task automatic issue(input logic [31:0] p, input logic sv, input logic te,
                       input logic pv, input logic ds, input logic df,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic bsv, input logic bte);
    @(negedge clk);
    pc = p; s = sv; et = te; ps = pv; dst = ds; fld = df;
    pcsr = a; bpcsr = b; bs = bsv; bet = bte; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic [31:0] epc,
                            input logic es, input logic ee, input logic ed,
                            input logic eh, input logic ei);
    chk(req, "commit", 32'(commit), 32'd1);
    chk(req, "next_pc", npc, epc);
    chk(req, "s", 32'(s_q), 32'(es));
    chk(req, "et", 32'(et_q), 32'(ee));
    chk(req, "dbg_clr", 32'(dclr), 32'(ed));
    chk(req, "halt", 32'(halt), 32'(eh));
    chk(req, "illegal", 32'(ill), 32'(ei));
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    chk(req, "commit idle", 32'(commit), 32'd0);
    chk(req, "pulses idle", {29'd0, halt, ill, dclr}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1", "commit", 32'(commit), 32'd0);
    chk("R1", "next_pc", npc, 32'd0);
    chk("R1", "flags", {27'd0, s_q, et_q, dclr, halt, ill}, 32'd0);
  endtask

  task automatic t_user;
    issue(32'h0000_1000, 0, 0, 1, 0, 0, 32'hAAAA_0000, 32'hBBBB_0000, 1, 1);
    expect_res("R2", 32'h0000_1004, 0, 0, 0, 1, 0);
    idle_check("R7");
    issue(32'h0000_2000, 0, 1, 1, 0, 0, 32'hAAAA_0000, 32'hBBBB_0000, 1, 0);
    expect_res("R2", 32'h0000_2004, 0, 1, 0, 0, 0);
  endtask

  task automatic t_et_err;
    issue(32'h0000_3000, 1, 1, 0, 1, 1, 32'hAAAA_0000, 32'hBBBB_0000, 0, 0);
    expect_res("R3", 32'h0000_3004, 1, 1, 0, 1, 1);
    idle_check("R7");
  endtask

  task automatic t_normal;
    issue(32'h0000_4000, 1, 0, 0, 0, 0, 32'h0001_2340, 32'hBBBB_0000, 1, 0);
    expect_res("R4", 32'h0001_2340, 0, 1, 0, 0, 0);
    issue(32'h0000_4000, 1, 0, 1, 0, 0, 32'h0001_5550, 32'hBBBB_0000, 0, 0);
    expect_res("R4", 32'h0001_5550, 1, 1, 0, 0, 0);
  endtask

  task automatic t_debug;
    issue(32'h0000_5000, 1, 0, 1, 1, 1, 32'hAAAA_0000, 32'h0007_7700, 0, 1);
    expect_res("R5", 32'h0007_7700, 0, 1, 1, 0, 0);
    idle_check("R7");
    issue(32'h0000_5000, 1, 0, 0, 1, 1, 32'hAAAA_0000, 32'h0007_8800, 1, 0);
    expect_res("R5", 32'h0007_8800, 1, 0, 1, 0, 0);
  endtask

  task automatic t_mismatch;
    issue(32'h0000_6000, 1, 0, 0, 1, 0, 32'hAAAA_0000, 32'hBBBB_0000, 0, 1);
    expect_res("R6", 32'h0000_6004, 1, 0, 0, 0, 0);
    issue(32'h0000_7000, 1, 0, 0, 0, 1, 32'hAAAA_0000, 32'hBBBB_0000, 0, 1);
    expect_res("R6", 32'h0000_7004, 1, 0, 0, 0, 0);
  endtask

  task automatic t_asis;
    issue(32'h0000_8000, 1, 0, 0, 0, 0, 32'h1234_5677, 32'h0, 0, 0);
    expect_res("R8", 32'h1234_5677, 0, 1, 0, 0, 0);
    issue(32'h0000_8000, 1, 0, 0, 1, 1, 32'h0, 32'hDEAD_BEE2, 1, 1);
    expect_res("R8", 32'hDEAD_BEE2, 1, 1, 1, 0, 0);
  endtask

  task automatic t_wrap;
    issue(32'hFFFF_FFFC, 1, 0, 0, 1, 0, 32'h1, 32'h2, 0, 0);
    expect_res("R9", 32'h0000_0000, 1, 0, 0, 0, 0);
  endtask

  task automatic t_priority;
    issue(32'h0000_9000, 0, 0, 1, 1, 1, 32'hAAAA_0000, 32'hBBBB_0000, 1, 1);
    expect_res("R10", 32'h0000_9004, 0, 0, 0, 1, 0);
    idle_check("R7");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_user();
    t_et_err();
    t_normal();
    t_debug();
    t_mismatch();
    t_asis();
    t_wrap();
    t_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule